// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs whole SMBus master transactions on its own by steering a byte-level I2C master controller that sits beside it. A client hands over one request: the transaction kind, the direction, a 7-bit target address, a command byte and, for block transfers, a byte count. The sequencer then issues START, sends the address and command bytes, inserts a repeated START when a read needs one, and moves the data bytes. It never touches the wire itself. It reacts to the controller's progress flags (byte slot ready, negative acknowledge, bus error, master held) and answers each one with strobes: start, stop, write a byte, read a byte, clear flags.

Outgoing payload comes from a byte stream that the sequencer pops one byte at a time. Received bytes leave on a second stream. Each request ends with a single done pulse that carries a result code. Bus faults and stalls run a recovery step on the controller before done is raised, so the next request finds it clean.

Top module: `smb_txn_seq`

## Requirements
- R1: `req_kind` codes are 0 quick (no data byte), 1 byte (one), 2 byte-data (one), 3 word (two, low byte first on either stream), 4 block (`req_len` bytes). The sequencer moves exactly that many data bytes.
- R2: A request is invalid if its kind code is 5 to 7, if it is a read that would move zero bytes (quick read, or block read with `req_len` 0), or if it is a block with `req_len` above `MAX_BLOCK`. Such a request gets done with `result` 3 in the following cycle, and no controller strobe is issued.
- R3: Byte-data, word and block transfers issue START, then write the byte {addr, 0}, then write the command byte.
- R4: After the command, a write moves straight to data bytes. A read pulses `ctl_start` again together with the write of {addr, 1}.
- R5: Quick and byte transfers issue START, write {addr, `req_read`} and send no command. A byte write sends `req_cmd` as its single data byte.
- R6: In the read phase, every ready flag pulses `ctl_rx_re` and puts `ctl_rx_byte` on `rd_data` with `rd_valid`. `ctl_nack_next` is high exactly when the byte being taken is the final one. It is also set when the read address goes out for a one-byte read. The final byte is followed by STOP and `result` 0.
- R7: In the write phase, each ready flag with bytes left pops `wr_data` (a pulse on `wr_take` in the same cycle) into `ctl_tx_byte`. A ready flag with no bytes left gives STOP and `result` 0.
- R8: A negative acknowledge in any phase gives `ctl_stop`, `ctl_clr_nack` and done with `result` 1, all in the cycle after it is serviced, and a return to idle.
- R9: A bus error flag, or loss of master while a phase is active, leads to a recovery cycle. In that cycle the sequencer pulses `ctl_clr_err` and `ctl_stop` together with done and `result` 2.
- R10: If no flag arrives for `TIMEOUT_CYC` cycles during a phase, the sequencer runs the same recovery with `result` 2. The count restarts at every serviced flag, so a transaction that makes progress may last longer than `TIMEOUT_CYC` in total.
- R11: `req_ready` is high only in idle. A request raised while a transaction runs is ignored. Done is a one-cycle pulse issued as the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_ready | output | 1 | Sequencer idle |
| req_kind | input | 3 | Transaction kind code |
| req_read | input | 1 | 1 for a read transaction |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte (data byte for a byte write) |
| req_len | input | LEN_W | Block byte count |
| wr_data | input | 8 | Head of the outgoing byte stream |
| wr_take | output | 1 | Pops `wr_data` this cycle |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished |
| result | output | 2 | 0 ok, 1 no device, 2 bus error, 3 invalid |
| ctl_start | output | 1 | Request START or repeated START |
| ctl_stop | output | 1 | Request STOP |
| ctl_tx_we | output | 1 | Write `ctl_tx_byte` to the controller |
| ctl_tx_byte | output | 8 | Byte to transmit |
| ctl_rx_re | output | 1 | Take the received byte |
| ctl_rx_byte | input | 8 | Controller's received byte |
| ctl_nack_next | output | 1 | Answer the byte in flight with NACK |
| ctl_clr_nack | output | 1 | Write-one-to-clear of the NACK flag |
| ctl_clr_err | output | 1 | Clear the controller's error flags |
| st_ready | input | 1 | Byte slot ready for service |
| st_nack | input | 1 | Negative acknowledge seen |
| st_buserr | input | 1 | Bus error seen |
| st_master | input | 1 | Controller holds the bus as master |

## Verification
The assertions assume a controller that holds each flag until it is serviced and drops `st_ready` on the first edge at which it sees a write, read or stop strobe. They also assume it raises `st_master` on the edge that carries a START, and that request fields are valid in the cycle `req_valid` is taken. The bench's controller model follows exactly this contract, with a programmable response delay. It injects a single fault (NACK, bus error, master loss or silence) at a chosen byte index, and it only raises requests while the sequencer is idle, apart from the one deliberate overlap used for R11.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;

   localparam logic [2:0] KIND_QUICK = 3'd0;
   localparam logic [2:0] KIND_BYTE  = 3'd1;
   localparam logic [2:0] KIND_BDATA = 3'd2;
   localparam logic [2:0] KIND_WORD  = 3'd3;
   localparam logic [2:0] KIND_BLOCK = 3'd4;

   localparam logic [1:0] RES_OK      = 2'd0;
   localparam logic [1:0] RES_NODEV   = 2'd1;
   localparam logic [1:0] RES_BUSERR  = 2'd2;
   localparam logic [1:0] RES_INVALID = 2'd3;

   typedef enum logic [2:0] {
      PH_IDLE, PH_ADDR, PH_CMD, PH_RSTART, PH_SHORT, PH_RD, PH_WR, PH_RECOVER
   } phase_e;

endpackage

// File: rtl/smbseq_decode.sv
module smbseq_decode
   import smbseq_pkg::*;
#(
   parameter int LEN_W     = 6,
   parameter int MAX_BLOCK = 32
) (
   input  logic [2:0]       kind,
   input  logic             is_read,
   input  logic [LEN_W-1:0] blk_len,
   output logic [LEN_W-1:0] xfer_len,
   output logic             reject,
   output logic             short_form,
   output logic             cmd_as_data
);
   localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BLOCK);

   logic unknown;

   always_comb begin
      unknown  = 1'b0;
      xfer_len = '0;
      unique case (kind)
         KIND_QUICK: xfer_len = '0;
         KIND_BYTE:  xfer_len = LEN_W'(1);
         KIND_BDATA: xfer_len = LEN_W'(1);
         KIND_WORD:  xfer_len = LEN_W'(2);
         KIND_BLOCK: xfer_len = blk_len;
         default:    unknown  = 1'b1;
      endcase
   end

   assign short_form  = (kind == KIND_QUICK) || (kind == KIND_BYTE);
   assign cmd_as_data = (kind == KIND_BYTE);
   assign reject      = unknown
                      || (is_read && (xfer_len == '0))
                      || ((kind == KIND_BLOCK) && (blk_len > LIMIT));
endmodule

// File: rtl/smbseq_watchdog.sv
module smbseq_watchdog #(
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   generate
      if (TIMEOUT_CYC == 0) begin : g_off
         assign expire = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(TIMEOUT_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
         logic [CW-1:0] quiet;

         assign expire = run && !kick && (quiet == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       quiet <= '0;
            else if (!run || kick || expire)  quiet <= '0;
            else                              quiet <= quiet + 1'b1;
         end

         assert_quiet_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
            quiet <= LAST);
         assert_expire_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            expire |=> (quiet == '0));
      end
   endgenerate
endmodule

// File: rtl/smbseq_fsm.sv
module smbseq_fsm
   import smbseq_pkg::*;
#(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_read,
   input  logic [6:0]       req_addr,
   input  logic [7:0]       req_cmd,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             reject,
   input  logic             short_form,
   input  logic             cmd_as_data,
   input  logic             expire,
   output logic             run,
   output logic             svc,
   output logic             req_ready,
   input  logic [7:0]       wr_data,
   output logic             wr_take,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic [1:0]       result,
   output logic             ctl_start,
   output logic             ctl_stop,
   output logic             ctl_tx_we,
   output logic [7:0]       ctl_tx_byte,
   output logic             ctl_rx_re,
   input  logic [7:0]       ctl_rx_byte,
   output logic             ctl_nack_next,
   output logic             ctl_clr_nack,
   output logic             ctl_clr_err,
   input  logic             st_ready,
   input  logic             st_nack,
   input  logic             st_buserr,
   input  logic             st_master
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   phase_e           phase;
   logic [7:0]       addr_byte;
   logic [7:0]       cmd_q;
   logic [LEN_W-1:0] left;
   logic             cmd_data_q;
   logic             guard;
   logic             fault;
   logic             clean;

   assign run       = (phase != PH_IDLE) && (phase != PH_RECOVER);
   assign svc       = run && !guard && (st_ready || st_nack || st_buserr);
   assign fault     = st_buserr || !st_master;
   assign clean     = svc && !fault && !st_nack;
   assign req_ready = (phase == PH_IDLE);
   assign wr_take   = clean && (phase == PH_WR) && (left != '0) && !cmd_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase         <= PH_IDLE;
         addr_byte     <= '0;
         cmd_q         <= '0;
         left          <= '0;
         cmd_data_q    <= 1'b0;
         guard         <= 1'b0;
         done          <= 1'b0;
         result        <= RES_OK;
         ctl_start     <= 1'b0;
         ctl_stop      <= 1'b0;
         ctl_tx_we     <= 1'b0;
         ctl_tx_byte   <= '0;
         ctl_rx_re     <= 1'b0;
         ctl_nack_next <= 1'b0;
         ctl_clr_nack  <= 1'b0;
         ctl_clr_err   <= 1'b0;
         rd_valid      <= 1'b0;
         rd_data       <= '0;
      end else begin
         done         <= 1'b0;
         ctl_start    <= 1'b0;
         ctl_stop     <= 1'b0;
         ctl_tx_we    <= 1'b0;
         ctl_rx_re    <= 1'b0;
         ctl_clr_nack <= 1'b0;
         ctl_clr_err  <= 1'b0;
         rd_valid     <= 1'b0;
         guard        <= 1'b0;
         if (phase == PH_IDLE) begin
            if (req_valid) begin
               if (reject) begin
                  done   <= 1'b1;
                  result <= RES_INVALID;
               end else begin
                  ctl_start     <= 1'b1;
                  guard         <= 1'b1;
                  ctl_nack_next <= 1'b0;
                  addr_byte     <= {req_addr, req_read};
                  cmd_q         <= req_cmd;
                  left          <= xfer_len;
                  cmd_data_q    <= cmd_as_data;
                  phase         <= short_form ? PH_SHORT : PH_ADDR;
               end
            end
         end else if (phase == PH_RECOVER) begin
            ctl_clr_err   <= 1'b1;
            ctl_stop      <= 1'b1;
            ctl_nack_next <= 1'b0;
            done          <= 1'b1;
            result        <= RES_BUSERR;
            phase         <= PH_IDLE;
         end else if (svc) begin
            if (fault) begin
               phase <= PH_RECOVER;
            end else if (st_nack) begin
               ctl_stop      <= 1'b1;
               ctl_clr_nack  <= 1'b1;
               ctl_nack_next <= 1'b0;
               done          <= 1'b1;
               result        <= RES_NODEV;
               phase         <= PH_IDLE;
            end else begin
               guard <= 1'b1;
               unique case (phase)
                  PH_ADDR: begin
                     ctl_tx_we   <= 1'b1;
                     ctl_tx_byte <= {addr_byte[7:1], 1'b0};
                     phase       <= PH_CMD;
                  end
                  PH_CMD: begin
                     ctl_tx_we   <= 1'b1;
                     ctl_tx_byte <= cmd_q;
                     phase       <= addr_byte[0] ? PH_RSTART : PH_WR;
                  end
                  PH_RSTART, PH_SHORT: begin
                     ctl_tx_we   <= 1'b1;
                     ctl_tx_byte <= addr_byte;
                     ctl_start   <= (phase == PH_RSTART);
                     if (addr_byte[0]) begin
                        ctl_nack_next <= (left == ONE);
                        phase         <= PH_RD;
                     end else begin
                        phase         <= PH_WR;
                     end
                  end
                  PH_RD: begin
                     ctl_nack_next <= (left == ONE);
                     ctl_rx_re     <= 1'b1;
                     rd_valid      <= 1'b1;
                     rd_data       <= ctl_rx_byte;
                     left          <= left - ONE;
                     if (left == ONE) begin
                        ctl_stop <= 1'b1;
                        done     <= 1'b1;
                        result   <= RES_OK;
                        phase    <= PH_IDLE;
                     end
                  end
                  PH_WR: begin
                     if (left == '0) begin
                        ctl_stop <= 1'b1;
                        done     <= 1'b1;
                        result   <= RES_OK;
                        phase    <= PH_IDLE;
                     end else begin
                        ctl_tx_we   <= 1'b1;
                        ctl_tx_byte <= cmd_data_q ? cmd_q : wr_data;
                        left        <= left - ONE;
                     end
                  end
                  default: phase <= PH_IDLE;
               endcase
            end
         end else if (expire) begin
            phase <= PH_RECOVER;
         end
      end
   end

   assert_done_in_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);
   assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && reject) |=> (done && result == RES_INVALID && !ctl_start));
   assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (svc && !fault && st_nack) |=> (ctl_stop && ctl_clr_nack && done && result == RES_NODEV));
   assert_fault_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (svc && fault) |=> (phase == PH_RECOVER));
   assert_recover_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RECOVER) |=> (done && ctl_clr_err && ctl_stop && result == RES_BUSERR));
   assert_rx_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ctl_rx_re);
   assert_one_data_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_tx_we, ctl_rx_re, wr_take}));
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
   import smbseq_pkg::*;
#(
   parameter int LEN_W       = 6,
   parameter int MAX_BLOCK   = 32,
   parameter int TIMEOUT_CYC = 250_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_kind,
   input  logic             req_read,
   input  logic [6:0]       req_addr,
   input  logic [7:0]       req_cmd,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wr_data,
   output logic             wr_take,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic [1:0]       result,
   output logic             ctl_start,
   output logic             ctl_stop,
   output logic             ctl_tx_we,
   output logic [7:0]       ctl_tx_byte,
   output logic             ctl_rx_re,
   input  logic [7:0]       ctl_rx_byte,
   output logic             ctl_nack_next,
   output logic             ctl_clr_nack,
   output logic             ctl_clr_err,
   input  logic             st_ready,
   input  logic             st_nack,
   input  logic             st_buserr,
   input  logic             st_master
);
   generate
      if (LEN_W < $clog2(MAX_BLOCK + 1)) begin : g_bad_len
         $error("LEN_W cannot hold MAX_BLOCK");
      end
      if (MAX_BLOCK < 2) begin : g_bad_max
         $error("MAX_BLOCK must allow a two-byte block");
      end
   endgenerate

   logic [LEN_W-1:0] xfer_len;
   logic             reject, short_form, cmd_as_data;
   logic             run, svc, expire;

   smbseq_decode #(.LEN_W(LEN_W), .MAX_BLOCK(MAX_BLOCK)) u_decode (
      .kind(req_kind), .is_read(req_read), .blk_len(req_len),
      .xfer_len(xfer_len), .reject(reject),
      .short_form(short_form), .cmd_as_data(cmd_as_data)
   );

   smbseq_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watchdog (
      .clk(clk), .rst_n(rst_n), .run(run), .kick(svc), .expire(expire)
   );

   smbseq_fsm #(.LEN_W(LEN_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
      .req_cmd(req_cmd), .xfer_len(xfer_len), .reject(reject),
      .short_form(short_form), .cmd_as_data(cmd_as_data),
      .expire(expire), .run(run), .svc(svc), .req_ready(req_ready),
      .wr_data(wr_data), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .done(done), .result(result),
      .ctl_start(ctl_start), .ctl_stop(ctl_stop),
      .ctl_tx_we(ctl_tx_we), .ctl_tx_byte(ctl_tx_byte),
      .ctl_rx_re(ctl_rx_re), .ctl_rx_byte(ctl_rx_byte),
      .ctl_nack_next(ctl_nack_next), .ctl_clr_nack(ctl_clr_nack),
      .ctl_clr_err(ctl_clr_err),
      .st_ready(st_ready), .st_nack(st_nack),
      .st_buserr(st_buserr), .st_master(st_master)
   );
endmodule

// File: tb/smb_txn_seq_test.sv
`timescale 1ns/1ps
module smb_txn_seq_test;
   localparam int LEN_W = 6;
   localparam int TOUT  = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [2:0]       req_kind = '0;
   logic             req_read = 1'b0;
   logic [6:0]       req_addr = '0;
   logic [7:0]       req_cmd = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [7:0]       wr_data;
   logic             wr_take, rd_valid, done;
   logic [7:0]       rd_data, ctl_tx_byte, ctl_rx_byte;
   logic [1:0]       result;
   logic ctl_start, ctl_stop, ctl_tx_we, ctl_rx_re, ctl_nack_next, ctl_clr_nack, ctl_clr_err;
   logic st_ready, st_nack, st_buserr, st_master;

   smb_txn_seq #(.LEN_W(LEN_W), .MAX_BLOCK(32), .TIMEOUT_CYC(TOUT)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_read(req_read), .req_addr(req_addr),
      .req_cmd(req_cmd), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .result(result),
      .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_tx_we(ctl_tx_we),
      .ctl_tx_byte(ctl_tx_byte), .ctl_rx_re(ctl_rx_re), .ctl_rx_byte(ctl_rx_byte),
      .ctl_nack_next(ctl_nack_next), .ctl_clr_nack(ctl_clr_nack),
      .ctl_clr_err(ctl_clr_err), .st_ready(st_ready), .st_nack(st_nack),
      .st_buserr(st_buserr), .st_master(st_master)
   );

   // ---------------- controller model ----------------
   logic [7:0] wrsrc [0:39];
   logic [7:0] rxsrc [0:39];
   logic [7:0] txlog [0:39];
   logic [7:0] rdlog [0:39];
   logic       acklog[0:39];
   int  wri, rxi;
   int  txn, starts, stops, clr_n, clr_e, pend, pend_fault;
   int  rdn, ackn;
   int  dly = 3;
   int  fault_at = -1;
   int  fault_kind = 0;   // 1 nack, 2 bus error, 3 silence, 4 master loss
   logic mdl_clr = 1'b0;

   assign wr_data     = wrsrc[wri];
   assign ctl_rx_byte = rxsrc[rxi];

   always @(posedge clk) begin
      if (mdl_clr) begin
         txn = 0; starts = 0; stops = 0; clr_n = 0; clr_e = 0; pend = 0; pend_fault = 0;
         st_ready <= 1'b0; st_nack <= 1'b0; st_buserr <= 1'b0; st_master <= 1'b0;
         wri <= 0; rxi <= 0;
      end else begin
         if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
               if (pend_fault == 1)      st_nack <= 1'b1;
               else if (pend_fault == 2) st_buserr <= 1'b1;
               else if (pend_fault == 4) begin st_ready <= 1'b1; st_master <= 1'b0; end
               else if (pend_fault != 3) st_ready <= 1'b1;
            end
         end
         if (ctl_start) begin starts++; st_master <= 1'b1; pend = dly; pend_fault = 0; end
         if (ctl_tx_we) begin
            txlog[txn] = ctl_tx_byte;
            pend_fault = (txn == fault_at) ? fault_kind : 0;
            pend = dly; txn++; st_ready <= 1'b0;
         end
         if (wr_take) wri <= wri + 1;
         if (ctl_rx_re) begin rxi <= rxi + 1; st_ready <= 1'b0; pend = dly; pend_fault = 0; end
         if (ctl_stop) begin stops++; st_master <= 1'b0; st_ready <= 1'b0; pend = 0; end
         if (ctl_clr_nack) begin clr_n++; st_nack <= 1'b0; end
         if (ctl_clr_err)  begin clr_e++; st_buserr <= 1'b0; end
      end
   end

   always @(negedge clk) begin
      if (mdl_clr) begin rdn = 0; ackn = 0; end
      else begin
         if (rd_valid)  begin rdlog[rdn] = rd_data; rdn++; end
         if (ctl_rx_re) begin acklog[ackn] = ctl_nack_next; ackn++; end
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_tx(input string tag, input int n, input int b0, input int b1, input int b2);
      chk({tag, " tx count"}, txn, n);
      if (n > 0) chk({tag, " tx0"}, txlog[0], b0);
      if (n > 1) chk({tag, " tx1"}, txlog[1], b1);
      if (n > 2) chk({tag, " tx2"}, txlog[2], b2);
   endtask

   task automatic xfer(input logic [2:0] k, input logic rd, input logic [6:0] a,
                       input logic [7:0] c, input int n, input bit poke,
                       output int res, output int cyc);
      @(negedge clk); mdl_clr = 1'b1;
      @(negedge clk); mdl_clr = 1'b0;
      req_kind = k; req_read = rd; req_addr = a; req_cmd = c; req_len = LEN_W'(n);
      req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      cyc = 1; res = -1;
      if (poke) begin
         @(negedge clk); cyc++;
         req_kind = 3'd0; req_read = 1'b0; req_addr = 7'h7F; req_valid = 1'b1;
         @(negedge clk); cyc++; req_valid = 1'b0;
      end
      while (!done && cyc < 6000) begin @(negedge clk); cyc++; end
      if (done) res = result;
      else begin n_bad++; n_chk++; $display("FAIL R11: no done, actual 0 expected 1"); end
      @(negedge clk);
      fault_at = -1; fault_kind = 0; dly = 3;
   endtask

   int res, cyc;

   task automatic t_reset;
      chk("R11 ready after reset", req_ready, 1);
      chk("R11 done quiet", done, 0);
      chk("R11 strobes quiet", {ctl_start, ctl_stop, ctl_tx_we, ctl_rx_re}, 0);
   endtask

   task automatic t_quick_write;
      xfer(3'd0, 1'b0, 7'h50, 8'h00, 0, 1'b0, res, cyc);
      chk("R5 quick result", res, 0);
      chk_tx("R5 quick", 1, 8'hA0, 0, 0);
      chk("R5 quick one start", starts, 1);
      chk("R7 quick stop", stops, 1);
   endtask

   task automatic t_byte_write;
      xfer(3'd1, 1'b0, 7'h21, 8'h5A, 0, 1'b0, res, cyc);
      chk("R5 byte write result", res, 0);
      chk_tx("R5 byte write", 2, 8'h42, 8'h5A, 0);
      chk("R5 byte write no pop", wri, 0);
   endtask

   task automatic t_byte_read;
      xfer(3'd1, 1'b1, 7'h21, 8'h00, 0, 1'b0, res, cyc);
      chk("R5 byte read result", res, 0);
      chk_tx("R5 byte read", 1, 8'h43, 0, 0);
      chk("R6 byte read count", rdn, 1);
      chk("R6 byte read data", rdlog[0], 8'hC0);
      chk("R6 byte read nack", acklog[0], 1);
   endtask

   task automatic t_bdata_write_busy;
      xfer(3'd2, 1'b0, 7'h10, 8'h07, 0, 1'b1, res, cyc);
      chk("R3 byte-data result", res, 0);
      chk_tx("R3 byte-data", 3, 8'h20, 8'h07, 8'h10);
      chk("R11 overlap ignored starts", starts, 1);
      chk("R7 one pop", wri, 1);
   endtask

   task automatic t_word_read;
      xfer(3'd3, 1'b1, 7'h11, 8'h33, 0, 1'b0, res, cyc);
      chk("R4 word read result", res, 0);
      chk_tx("R4 word read", 3, 8'h22, 8'h33, 8'h23);
      chk("R4 repeated start", starts, 2);
      chk("R1 word low first", rdlog[0], 8'hC0);
      chk("R1 word high second", rdlog[1], 8'hC1);
      chk("R6 word nack pattern", {acklog[0], acklog[1]}, 2'b01);
   endtask

   task automatic t_word_write;
      wrsrc[0] = 8'h34; wrsrc[1] = 8'h12;
      xfer(3'd3, 1'b0, 7'h11, 8'h44, 0, 1'b0, res, cyc);
      chk("R4 word write result", res, 0);
      chk_tx("R1 word write", 4, 8'h22, 8'h44, 8'h34);
      chk("R1 word write high byte", txlog[3], 8'h12);
      chk("R4 word write single start", starts, 1);
      for (int i = 0; i < 40; i++) wrsrc[i] = 8'h10 + 8'(i);
   endtask

   task automatic t_block_write;
      xfer(3'd4, 1'b0, 7'h08, 8'hE1, 3, 1'b0, res, cyc);
      chk("R7 block write result", res, 0);
      chk_tx("R3 block write", 5, 8'h10, 8'hE1, 8'h10);
      chk("R7 block tail", {txlog[3], txlog[4]}, 16'h1112);
      chk("R7 block pops", wri, 3);
      chk("R7 block stop", stops, 1);
   endtask

   task automatic t_block_read_max;
      xfer(3'd4, 1'b1, 7'h09, 8'h02, 32, 1'b0, res, cyc);
      chk("R1 block read result", res, 0);
      chk("R1 block read count", rdn, 32);
      for (int i = 0; i < 32; i++) chk("R6 block read data", rdlog[i], 8'hC0 + i);
      chk("R6 nack before last", acklog[30], 0);
      chk("R6 nack on last", acklog[31], 1);
      chk("R4 block read addr", txlog[2], 8'h13);
   endtask

   task automatic t_invalid;
      xfer(3'd4, 1'b0, 7'h09, 8'h02, 33, 1'b0, res, cyc);
      chk("R2 block over limit", res, 3);
      chk("R2 over limit no start", starts, 0);
      chk("R2 invalid latency", cyc, 1);
      xfer(3'd0, 1'b1, 7'h09, 8'h02, 0, 1'b0, res, cyc);
      chk("R2 quick read", res, 3);
      xfer(3'd4, 1'b1, 7'h09, 8'h02, 0, 1'b0, res, cyc);
      chk("R2 empty block read", res, 3);
      xfer(3'd6, 1'b0, 7'h09, 8'h02, 1, 1'b0, res, cyc);
      chk("R2 unknown kind", res, 3);
      chk("R2 unknown no tx", txn, 0);
   endtask

   task automatic t_nack;
      fault_at = 0; fault_kind = 1;
      xfer(3'd2, 1'b0, 7'h3C, 8'h01, 0, 1'b0, res, cyc);
      chk("R8 nack result", res, 1);
      chk("R8 nack stop", stops, 1);
      chk("R8 nack cleared", clr_n, 1);
      chk("R8 nack no command", txn, 1);
   endtask

   task automatic t_buserr;
      fault_at = 1; fault_kind = 2;
      xfer(3'd4, 1'b0, 7'h3C, 8'h01, 4, 1'b0, res, cyc);
      chk("R9 bus error result", res, 2);
      chk("R9 bus error clear", clr_e, 1);
      chk("R9 bus error stop", stops, 1);
      chk("R9 bus error halted", txn, 2);
   endtask

   task automatic t_master_loss;
      fault_at = 0; fault_kind = 4;
      xfer(3'd2, 1'b0, 7'h3C, 8'h01, 0, 1'b0, res, cyc);
      chk("R9 master loss result", res, 2);
      chk("R9 master loss clear", clr_e, 1);
   endtask

   task automatic t_timeout;
      fault_at = 0; fault_kind = 3;
      xfer(3'd0, 1'b0, 7'h3C, 8'h00, 0, 1'b0, res, cyc);
      chk("R10 timeout result", res, 2);
      chk("R10 timeout recovery", clr_e, 1);
      chk("R10 timeout not early", int'(cyc >= TOUT), 1);
      chk("R10 timeout not late", int'(cyc <= TOUT + 20), 1);
   endtask

   task automatic t_kick;
      dly = 150;
      xfer(3'd4, 1'b0, 7'h05, 8'h06, 2, 1'b0, res, cyc);
      chk("R10 progress restarts count", res, 0);
      chk("R10 long transaction", int'(cyc > TOUT), 1);
   endtask

   initial begin
      for (int i = 0; i < 40; i++) begin
         wrsrc[i] = 8'h10 + 8'(i);
         rxsrc[i] = 8'hC0 + 8'(i);
      end
      mdl_clr = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mdl_clr = 1'b0;
      @(negedge clk);
      t_reset;
      t_quick_write;
      t_byte_write;
      t_byte_read;
      t_bdata_write_busy;
      t_word_read;
      t_word_write;
      t_block_write;
      t_block_read_max;
      t_invalid;
      t_nack;
      t_buserr;
      t_master_loss;
      t_timeout;
      t_kick;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule